// File: doc/BRIEF.md
# Fibonacci-Weighted Crosstalk-Avoiding Bus Encoder

This block turns a binary value into an M-bit codeword meant to drive a group of long, adjacent on-chip wires. No codeword ever shows a lone wire that differs from both of its neighbours, so the patterns `010` and `101` never appear. This bounds the worst coupling load any single wire sees. Bit k of the codeword (counting k = 1 at the least significant wire) carries the Fibonacci weight f_k, with f_1 = f_2 = 1 and f_k = f_(k-1) + f_(k-2). The sum of the weights of the set bits equals the input value.

The bits are found one per clock, from the top wire down, by tracking a remainder. Bit M is set when the value reaches f_(M+1). Each lower bit k from M-1 down to 2 is set when the remainder reaches f_(k+1) and cleared when the remainder is below f_k. In the band between those two thresholds it repeats the bit just resolved above it. Whenever a bit is set, its weight is subtracted from the remainder. The final remainder, 0 or 1, becomes bit 1. A producer hands in values with a valid/ready handshake, and the codeword appears with a one-cycle valid strobe. A value outside the codeable range is refused with a one-cycle error strobe.

Top module: `fpf_encoder`

## Requirements
- R1: While reset is held at a clock edge, and right after it, `in_ready` is 1 and `out_valid`, `out_err` and `out_code` are all 0.
- R2: `in_ready` is 1 only while the encoder is idle. A value is taken on an edge where `in_valid` and `in_ready` are both 1. While a conversion runs, `in_ready` is 0, `in_valid` is ignored, and the running result does not change.
- R3: For an accepted in-range value, `out_valid` rises on the (M-1)-th clock edge after the accepting edge and stays high for exactly one cycle.
- R4: Codeword bit M (`out_code[M-1]`) is 1 exactly when the value is at least f_(M+1). For M = 6, the value 13 yields `110000`.
- R5: For k from M-1 down to 2, bit k is 1 if the running remainder is at least f_(k+1), 0 if it is below f_k, and otherwise a copy of bit k+1. For M = 6, the value 8 yields `011000` and 7 yields `001111`.
- R6: Bit 1 (`out_code[0]`) equals the remainder left after bit 2, which is always 0 or 1. For M = 6, 1 yields `000001` and 2 yields `000011`.
- R7: No codeword contains `010` or `101` on any three adjacent bits.
- R8: The sum over set bits of f_(i+1), where i is the bit position in `out_code`, equals the accepted value, for every value from 0 to f_(M+2)-1.
- R9: A value of f_(M+2) or more (21 or more when M = 6) is accepted and then refused. `out_err` pulses for one cycle on the next edge, no `out_valid` follows, and `in_ready` stays 1.
- R10: `out_code` keeps its last codeword while the encoder is idle. This holds even across a refused value.
- R11: The two ends of the range encode to all-zeros and all-ones. For M = 6, 0 yields `000000`, 20 yields `111111` and 15 yields `110011`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers `in_value` |
| in_ready | output | 1 | Encoder idle and able to take a value |
| in_value | input | VW | Binary value; VW = ceil(log2(f_(M+2))) |
| out_valid | output | 1 | One-cycle strobe: `out_code` holds a new codeword |
| out_code | output | M | Codeword; bit i carries weight f_(i+1) |
| out_err | output | 1 | One-cycle strobe: the last value taken was out of range |

## Verification
The embedded properties assume that `in_valid` and `in_value` are settled and known at every rising edge. They also assume that a value taken while idle is a plain binary number: any value is allowed, and the range test inside the block decides whether it is coded or refused. The stimulus changes inputs only on falling edges and drops `in_valid` after the accepting edge, except in the one case where it is deliberately held through a busy period. Out-of-range values and a reset in the middle of a conversion are applied as separate directed cases, so the properties on the remainder only ever see values that passed the range test.

// File: rtl/fpf_pkg.sv
// Package: shared helpers for the Fibonacci-weighted crosstalk-avoiding encoder.
// Assumes: arguments to the elaboration-time functions are small (M below ~40).
package fpf_pkg;

    // Returns the n-th Fibonacci number with fib_num(0)=0, fib_num(1)=1.
    function automatic int fib_num(input int n);
        int a;
        int b;
        int t;
        a = 0;
        b = 1;
        for (int i = 0; i < n; i++) begin
            t = a + b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    // Bits needed to carry every legal input value 0 .. fib(m+2)-1.
    function automatic int val_width(input int m);
        return $clog2(fib_num(m + 2));
    endfunction

    // Controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } enc_state_t;

endpackage

// File: rtl/fpf_weight_sel.sv
// Module: Fibonacci weight table and selector.
// Builds the weights f_0 .. f_(M+1) at elaboration and returns f_idx and
// f_(idx+1) for the bit position being resolved.
// Assumes: idx lies in 1 .. M whenever the outputs are used; otherwise they read 0.
module fpf_weight_sel
    import fpf_pkg::*;
#(
    parameter int M  = 6,
    parameter int VW = 5,
    parameter int IW = 3
) (
    input  logic [IW-1:0] idx,
    output logic [VW-1:0] w_lo,
    output logic [VW-1:0] w_hi
);

    localparam int NW = M + 2;

    logic [VW-1:0] tab [0:NW-1];

    // One constant entry per Fibonacci index.
    for (genvar g = 0; g < NW; g++) begin : g_tab
        assign tab[g] = VW'(fib_num(g));
    end

    // Picks the pair of weights bracketing the current bit position.
    always_comb begin
        w_lo = '0;
        w_hi = '0;
        for (int i = 1; i <= M; i++) begin
            if (idx == IW'(i)) begin
                w_lo = tab[i];
                w_hi = tab[i + 1];
            end
        end
    end

endmodule

// File: rtl/fpf_bit_step.sv
// Module: one resolution step of the remainder-tracking encoder.
// Given the remainder and the weights f_k and f_(k+1), decides bit k and the
// next remainder. With prev_bit = 0 it also serves the top bit.
// Assumes: rem < f_(k+2), so a set bit never drives the remainder below zero.
module fpf_bit_step #(
    parameter int VW = 5
) (
    input  logic [VW-1:0] rem,
    input  logic [VW-1:0] w_lo,
    input  logic [VW-1:0] w_hi,
    input  logic          prev_bit,
    output logic          bit_o,
    output logic [VW-1:0] rem_nx
);

    // Two threshold compares, then copy the upper neighbour inside the band.
    always_comb begin
        if (rem >= w_hi) begin
            bit_o = 1'b1;
        end else if (rem < w_lo) begin
            bit_o = 1'b0;
        end else begin
            bit_o = prev_bit;
        end
        rem_nx = bit_o ? (rem - w_lo) : rem;
    end

endmodule

// File: rtl/fpf_seq_ctrl.sv
// Module: sequencing controller for the iterative encoder.
// Takes a value when idle, walks the bit index from M down to 2 (one per
// clock), then strobes out_valid. A value failing the range test is refused
// with a one-cycle err strobe and the controller stays idle.
// Assumes: M >= 3; in_legal is a function of the offered value only.
module fpf_seq_ctrl
    import fpf_pkg::*;
#(
    parameter int M  = 6,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_legal,
    output logic          in_ready,
    output logic          load,
    output logic          run,
    output logic          last_step,
    output logic [IW-1:0] idx,
    output logic          out_valid,
    output logic          out_err
);

    enc_state_t state_q;

    // Handshake and phase decode.
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        load      = in_ready && in_valid && in_legal;
        run       = (state_q == ST_RUN);
        last_step = run && (idx == IW'(2));
    end

    // State, bit index and result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx       <= '0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        if (in_legal) begin
                            state_q <= ST_RUN;
                            idx     <= IW'(M);
                        end else begin
                            out_err <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (idx == IW'(2)) begin
                        state_q   <= ST_IDLE;
                        out_valid <= 1'b1;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a taken value makes the encoder busy on the next cycle.
    p_busy_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !in_ready);

    // R3: the result strobe lasts one cycle.
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3: the result strobe only follows a running conversion.
    p_valid_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(run));

    // R9: a refused value yields an error strobe and leaves the encoder idle.
    p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid && !in_legal) |=> (out_err && in_ready && !out_valid));

    // R5: the bit index stays within the resolvable range while running.
    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (idx >= IW'(2) && idx <= IW'(M)));

endmodule

// File: rtl/fpf_encoder.sv
// Module: Fibonacci-weighted crosstalk-avoiding bus encoder (top).
// Converts a binary value into an M-bit codeword free of 010/101 patterns,
// resolving one bit per clock from the top down; out_valid strobes M-1 clocks
// after the value is taken. Values of f_(M+2) or more are refused via out_err.
// Assumes: M >= 3; inputs settle before each rising edge.
module fpf_encoder
    import fpf_pkg::*;
#(
    parameter  int M  = 6,
    localparam int VW = val_width(M)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [VW-1:0] in_value,
    output logic          out_valid,
    output logic [M-1:0]  out_code,
    output logic          out_err
);

    localparam int IW    = $clog2(M + 1);
    localparam int LIMIT = fib_num(M + 2);

    logic          in_legal;
    logic          load;
    logic          run;
    logic          last_step;
    logic [IW-1:0] idx;
    logic [VW-1:0] w_lo;
    logic [VW-1:0] w_hi;
    logic [VW-1:0] rem_q;
    logic          prev_q;
    logic          bit_now;
    logic [VW-1:0] rem_nx;
    logic [M-1:0]  code_q;
    logic [VW-1:0] chk_value;

    // Range test against the first value the codeword cannot carry.
    always_comb begin
        in_legal = ({1'b0, in_value} < (VW + 1)'(LIMIT));
    end

    fpf_seq_ctrl #(
        .M  (M),
        .IW (IW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_legal  (in_legal),
        .in_ready  (in_ready),
        .load      (load),
        .run       (run),
        .last_step (last_step),
        .idx       (idx),
        .out_valid (out_valid),
        .out_err   (out_err)
    );

    fpf_weight_sel #(
        .M  (M),
        .VW (VW),
        .IW (IW)
    ) u_wsel (
        .idx  (idx),
        .w_lo (w_lo),
        .w_hi (w_hi)
    );

    fpf_bit_step #(
        .VW (VW)
    ) u_step (
        .rem      (rem_q),
        .w_lo     (w_lo),
        .w_hi     (w_hi),
        .prev_bit (prev_q),
        .bit_o    (bit_now),
        .rem_nx   (rem_nx)
    );

    // Remainder, upper-neighbour bit and codeword registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= '0;
            prev_q    <= 1'b0;
            code_q    <= '0;
            chk_value <= '0;
        end else if (load) begin
            rem_q     <= in_value;
            prev_q    <= 1'b0;
            chk_value <= in_value;
        end else if (run) begin
            rem_q  <= rem_nx;
            prev_q <= bit_now;
            for (int i = 1; i <= M; i++) begin
                if (idx == IW'(i)) begin
                    code_q[i-1] <= bit_now;
                end
            end
            if (last_step) begin
                code_q[0] <= rem_nx[0];
            end
        end
    end

    assign out_code = code_q;

    // Check-only views of the finished codeword.
    logic code_bad;
    int   code_sum;

    // Scans adjacent triples and totals the Fibonacci weights of set bits.
    always_comb begin
        code_bad = 1'b0;
        code_sum = 0;
        for (int i = 0; i + 2 < M; i++) begin
            if (code_q[i+2 -: 3] == 3'b010 || code_q[i+2 -: 3] == 3'b101) begin
                code_bad = 1'b1;
            end
        end
        for (int i = 0; i < M; i++) begin
            if (code_q[i]) begin
                code_sum = code_sum + fib_num(i + 1);
            end
        end
    end

    // R6: what is left after bit 2 fits in a single bit.
    p_last_rem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_step |-> (rem_nx <= VW'(1)));

    // R5: a step never grows the remainder.
    p_rem_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (rem_nx <= rem_q));

    // R7: a presented codeword is free of isolated bits.
    p_no_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !code_bad);

    // R8: the weighted sum of a presented codeword matches the taken value.
    p_weight_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (code_sum == int'(chk_value)));

    // R10: the codeword holds while the encoder stays idle.
    p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && $past(in_ready)) |-> $stable(out_code));

endmodule

// File: tb/tb_fpf_encoder.sv
// Bench for fpf_encoder with default M = 6 (5-bit values, range 0..20).
module tb_fpf_encoder;

    logic       clk;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [4:0] in_value;
    logic       out_valid;
    logic [5:0] out_code;
    logic       out_err;

    int checks = 0;
    int errors = 0;

    fpf_encoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_value  (in_value),
        .out_valid (out_valid),
        .out_code  (out_code),
        .out_err   (out_err)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    localparam int NV = 8;
    localparam logic [4:0] VEC_IN   [NV] = '{5'd0, 5'd1, 5'd2, 5'd7, 5'd8, 5'd13, 5'd15, 5'd20};
    localparam logic [5:0] VEC_CODE [NV] = '{6'b000000, 6'b000001, 6'b000011, 6'b001111,
                                             6'b011000, 6'b110000, 6'b110011, 6'b111111};
    localparam string VEC_REQ [NV] = '{"R11", "R6", "R6", "R5", "R5", "R4", "R11", "R11"};

    localparam int FIB [1:6] = '{1, 1, 2, 3, 5, 8};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    function automatic bit isolated(input logic [5:0] c);
        bit bad = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (c[i+2 -: 3] == 3'b010 || c[i+2 -: 3] == 3'b101) bad = 1'b1;
        end
        return bad;
    endfunction

    function automatic int wsum(input logic [5:0] c);
        int s = 0;
        for (int i = 0; i < 6; i++) if (c[i]) s += FIB[i+1];
        return s;
    endfunction

    // Offers v for one cycle; reports error strobe, codeword and latency.
    task automatic encode(input logic [4:0] v, output logic [5:0] code,
                          output bit err, output int lat);
        @(negedge clk);
        check(in_ready == 1'b1, "R2", "ready before offer", int'(in_ready), 1);
        in_valid = 1'b1;
        in_value = v;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        err  = out_err;
        code = out_code;
        lat  = 0;
        check(out_valid == 1'b0, "R3", "no strobe at accept", int'(out_valid), 0);
        if (err) return;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (out_valid) begin
                lat  = k;
                code = out_code;
                break;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R3", "strobe one cycle", int'(out_valid), 0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] code;
        logic [5:0] held;
        bit         err;
        int         lat;

        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_value = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: values under reset
        check(in_ready == 1'b1, "R1", "ready in reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
        check(out_err == 1'b0, "R1", "err in reset", int'(out_err), 0);
        check(out_code == 6'b0, "R1", "code in reset", int'(out_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after reset",
              int'({in_ready, out_valid}), 2);

        // Vector table: exact codewords
        for (int n = 0; n < NV; n++) begin
            encode(VEC_IN[n], code, err, lat);
            check(err == 1'b0, VEC_REQ[n], "no error", int'(err), 0);
            check(code == VEC_CODE[n], VEC_REQ[n], $sformatf("code of %0d", VEC_IN[n]),
                  int'(code), int'(VEC_CODE[n]));
            check(lat == 5, "R3", "latency", lat, 5);
        end

        // Whole range: pattern freedom and weighted sum (R7, R8)
        for (int v = 0; v <= 20; v++) begin
            encode(5'(v), code, err, lat);
            check(!isolated(code), "R7", $sformatf("isolated bit for %0d", v), int'(code), 0);
            check(wsum(code) == v, "R8", "weighted sum", wsum(code), v);
            check(lat == 5, "R3", "latency sweep", lat, 5);
        end

        // R9 and R10: refused values leave the last codeword in place
        held = out_code;
        foreach (VEC_IN[n]) begin end
        for (int v = 21; v <= 31; v += 10) begin
            encode(5'(v), code, err, lat);
            check(err == 1'b1, "R9", $sformatf("error for %0d", v), int'(err), 1);
            check(in_ready == 1'b1, "R9", "ready on refusal", int'(in_ready), 1);
            check(out_code == held, "R10", "code held", int'(out_code), int'(held));
            @(negedge clk);
            check(out_err == 1'b0 && out_valid == 1'b0, "R9", "single error, no result",
                  int'({out_err, out_valid}), 0);
        end

        // R2: offers while busy are ignored
        @(negedge clk);
        in_valid = 1'b1;
        in_value = 5'd15;
        @(posedge clk);
        @(negedge clk);
        in_value = 5'd7;
        for (int k = 0; k < 3; k++) begin
            check(in_ready == 1'b0, "R2", "busy not ready", int'(in_ready), 0);
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        for (int k = 0; k < 5 && !out_valid; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check(out_valid == 1'b1, "R2", "result after busy offers", int'(out_valid), 1);
        check(out_code == 6'b110011, "R2", "busy offer ignored", int'(out_code), 'b110011);

        // R1: reset mid-conversion aborts it
        @(negedge clk);
        in_valid = 1'b1;
        in_value = 5'd20;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1 && out_code == 6'b0, "R1", "mid-run reset",
              int'({in_ready, out_code}), 64);
        rst_n = 1'b1;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (out_valid) seen = 1'b1;
            end
            check(seen == 1'b0, "R1", "no result after abort", int'(seen), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule